// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt

This block watches a live calendar value (year, month, day of month, day of week, hour, minute, second) that a separate counter supplies, and compares it with an alarm time held in two setup words. Each of the seven fields has its own compare-enable bit. A field whose enable is clear always counts as matching. A global arm bit gates the whole comparison, and a read-only flag in the first setup word shows, one clock later, that matching is armed.

When every enabled field equals the live value, the block sets a sticky raw interrupt. It sets it once for each new match event, and it stays set until software clears the global arm bit. The raw bit then passes through a mask stage and a force stage to drive the interrupt line. Software writes the setup words and the mask and force bits through simple write strobes that share one data bus. Software must not change alarm fields or field enables while the block is armed.

Top module: `cal_alarm_irq`

## Requirements
- R1: After synchronous reset, both setup readbacks are zero, and the raw bit, the mask bit, the force bit and the interrupt line are all low.
- R2: A write to setup word 0 stores year in bits 23:12, month in 11:8 and day of month in 4:0. It stores the enables for day (bit 24), month (bit 25) and year (bit 26), and the global arm bit at 28. All other bits read back as 0, and bit 29 cannot be written.
- R3: A write to setup word 1 stores day of week in bits 26:24, hour in 20:16, minute in 13:8 and second in 5:0. It stores the enables for second (bit 28), minute (bit 29), hour (bit 30) and day of week (bit 31). All other bits read back as 0.
- R4: Bit 29 of the setup word 0 readback (the armed flag) equals the global arm bit delayed by one clock.
- R5: While armed, the raw bit rises on the clock edge after the cycle in which all enabled fields first equal the live calendar. Fields whose enable is clear do not affect the result.
- R6: The raw bit stays high after the live value stops matching. It falls on the clock edge after the global arm bit is cleared, and it can fire again once the block is re-armed.
- R7: With the global arm bit set but no field enable set, the raw bit never rises.
- R8: The interrupt line equals (raw AND mask) OR force. The mask and force bits are written from data bit 0 by their own strobes, and they are read back.
- R9: A mismatch in any single enabled field keeps the raw bit low, even when every other enabled field matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_year | input | 12 | Live year |
| cal_month | input | 4 | Live month |
| cal_day | input | 5 | Live day of month |
| cal_wday | input | 3 | Live day of week |
| cal_hour | input | 5 | Live hour |
| cal_min | input | 6 | Live minute |
| cal_sec | input | 6 | Live second |
| wr_setup0 | input | 1 | Write strobe for setup word 0 |
| wr_setup1 | input | 1 | Write strobe for setup word 1 |
| wr_mask | input | 1 | Write strobe for interrupt mask bit |
| wr_force | input | 1 | Write strobe for interrupt force bit |
| wr_data | input | 32 | Write data shared by all strobes |
| setup0_rd | output | 32 | Setup word 0 readback including armed flag |
| setup1_rd | output | 32 | Setup word 1 readback |
| irq_raw | output | 1 | Sticky raw alarm bit |
| irq_mask | output | 1 | Interrupt mask bit |
| irq_force | output | 1 | Interrupt force bit |
| irq_out | output | 1 | Interrupt line after mask and force |

## Verification
The compare function is driven from one live date and a set of enable patterns: a single enabled field that matches, all seven enabled and equal, all seven with the second off by one, one enabled month that differs, a differing field that is disabled, no enables at all, and a full match while disarmed. Together these separate the AND across enabled fields from an OR. They also show whether disabled fields are treated as don't-care, and whether the arm bit and the empty-enable case gate the result. Directed steps check the edge timing of the raw bit, its stickiness after a mismatch, clearing and re-firing through the arm bit, and each combination of mask and force.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

    localparam int YEAR_W  = 12;
    localparam int MONTH_W = 4;
    localparam int DAY_W   = 5;
    localparam int WDAY_W  = 3;
    localparam int HOUR_W  = 5;
    localparam int MIN_W   = 6;
    localparam int SEC_W   = 6;
    localparam int NFIELD  = 7;
    localparam int FIELD_W = YEAR_W;
    localparam int WORD_W  = 32;

    // field index order used for the enable vector
    typedef enum int {
        F_SEC = 0, F_MIN = 1, F_HOUR = 2, F_WDAY = 3,
        F_DAY = 4, F_MONTH = 5, F_YEAR = 6
    } field_e;

    typedef struct packed {
        logic [YEAR_W-1:0]  year;
        logic [MONTH_W-1:0] month;
        logic [DAY_W-1:0]   day;
        logic [WDAY_W-1:0]  wday;
        logic [HOUR_W-1:0]  hour;
        logic [MIN_W-1:0]   minute;
        logic [SEC_W-1:0]   second;
    } cal_t;

    // setup word 0 layout
    localparam int S0_DAY_LO   = 0;
    localparam int S0_MONTH_LO = 8;
    localparam int S0_YEAR_LO  = 12;
    localparam int S0_EN_DAY   = 24;
    localparam int S0_EN_MONTH = 25;
    localparam int S0_EN_YEAR  = 26;
    localparam int S0_ARM      = 28;
    localparam int S0_ARMED    = 29;
    localparam logic [WORD_W-1:0] S0_WMASK = 32'h17ff_ff1f;

    // setup word 1 layout
    localparam int S1_SEC_LO  = 0;
    localparam int S1_MIN_LO  = 8;
    localparam int S1_HOUR_LO = 16;
    localparam int S1_WDAY_LO = 24;
    localparam int S1_EN_SEC  = 28;
    localparam int S1_EN_MIN  = 29;
    localparam int S1_EN_HOUR = 30;
    localparam int S1_EN_WDAY = 31;
    localparam logic [WORD_W-1:0] S1_WMASK = 32'hf71f_3f3f;

    function automatic cal_t unpack_alarm(input logic [WORD_W-1:0] w0,
                                          input logic [WORD_W-1:0] w1);
        cal_t c;
        c.year   = w0[S0_YEAR_LO  +: YEAR_W];
        c.month  = w0[S0_MONTH_LO +: MONTH_W];
        c.day    = w0[S0_DAY_LO   +: DAY_W];
        c.wday   = w1[S1_WDAY_LO  +: WDAY_W];
        c.hour   = w1[S1_HOUR_LO  +: HOUR_W];
        c.minute = w1[S1_MIN_LO   +: MIN_W];
        c.second = w1[S1_SEC_LO   +: SEC_W];
        return c;
    endfunction

    function automatic logic [NFIELD-1:0] unpack_enables(input logic [WORD_W-1:0] w0,
                                                         input logic [WORD_W-1:0] w1);
        logic [NFIELD-1:0] e;
        e[F_SEC]   = w1[S1_EN_SEC];
        e[F_MIN]   = w1[S1_EN_MIN];
        e[F_HOUR]  = w1[S1_EN_HOUR];
        e[F_WDAY]  = w1[S1_EN_WDAY];
        e[F_DAY]   = w0[S0_EN_DAY];
        e[F_MONTH] = w0[S0_EN_MONTH];
        e[F_YEAR]  = w0[S0_EN_YEAR];
        return e;
    endfunction

    // one field zero-extended to a common width
    function automatic logic [FIELD_W-1:0] field_of(input cal_t c, input int idx);
        logic [FIELD_W-1:0] v;
        v = '0;
        case (idx)
            F_SEC:   v[SEC_W-1:0]   = c.second;
            F_MIN:   v[MIN_W-1:0]   = c.minute;
            F_HOUR:  v[HOUR_W-1:0]  = c.hour;
            F_WDAY:  v[WDAY_W-1:0]  = c.wday;
            F_DAY:   v[DAY_W-1:0]   = c.day;
            F_MONTH: v[MONTH_W-1:0] = c.month;
            default: v              = c.year;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
    import cal_alarm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_setup0,
    input  logic                wr_setup1,
    input  logic [WORD_W-1:0]   wr_data,
    output cal_t                alarm,
    output logic [NFIELD-1:0]   field_en,
    output logic                arm,
    output logic                armed,
    output logic [WORD_W-1:0]   setup0_rd,
    output logic [WORD_W-1:0]   setup1_rd
);
    logic [WORD_W-1:0] s0_q, s1_q;
    logic              armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_q    <= '0;
            s1_q    <= '0;
            armed_q <= 1'b0;
        end else begin
            if (wr_setup0) s0_q <= wr_data & S0_WMASK;
            if (wr_setup1) s1_q <= wr_data & S1_WMASK;
            armed_q <= s0_q[S0_ARM];
        end
    end

    always_comb begin
        alarm     = unpack_alarm(s0_q, s1_q);
        field_en  = unpack_enables(s0_q, s1_q);
        arm       = s0_q[S0_ARM];
        armed     = armed_q;
        setup0_rd = s0_q;
        setup0_rd[S0_ARMED] = armed_q;
        setup1_rd = s1_q;
    end

    // R4: armed flag trails the arm bit by one clock
    a_r4_armed_rise: assert property (@(posedge clk) disable iff (rst)
        arm |=> armed);
    a_r4_armed_fall: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !armed);

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cal_t              live,
    input  cal_t              alarm,
    input  logic [NFIELD-1:0] field_en,
    input  logic              arm,
    output logic              match_now,
    output logic              match_event
);
    logic [NFIELD-1:0] field_ok;
    logic              hit_q;

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        assign field_ok[i] = !field_en[i] ||
                             (field_of(live, i) == field_of(alarm, i));
    end

    assign match_now   = arm && (|field_en) && (&field_ok);
    assign match_event = match_now && !hit_q;

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= match_now;
    end

endmodule

// File: rtl/cal_alarm_intc.sv
module cal_alarm_intc
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              any_en,
    input  logic              match_now,
    input  logic              match_event,
    input  logic              wr_mask,
    input  logic              wr_force,
    input  logic              wr_bit,
    output logic              raw,
    output logic              mask,
    output logic              force_q,
    output logic              line
);
    always_ff @(posedge clk) begin
        if (rst) begin
            raw     <= 1'b0;
            mask    <= 1'b0;
            force_q <= 1'b0;
        end else begin
            if (!arm)             raw <= 1'b0;
            else if (match_event) raw <= 1'b1;
            if (wr_mask)  mask    <= wr_bit;
            if (wr_force) force_q <= wr_bit;
        end
    end

    assign line = (raw & mask) | force_q;

    // R6: disarming clears the raw bit on the next edge
    a_r6_clear_on_disarm: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !raw);
    // R5: a rise of raw follows a cycle with a live match
    a_r5_rise_needs_match: assert property (@(posedge clk) disable iff (rst)
        $rose(raw) |-> $past(match_now));
    // R7: a rise of raw needs at least one field enable
    a_r7_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(raw) |-> $past(any_en));

endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq
    import cal_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [YEAR_W-1:0]  cal_year,
    input  logic [MONTH_W-1:0] cal_month,
    input  logic [DAY_W-1:0]   cal_day,
    input  logic [WDAY_W-1:0]  cal_wday,
    input  logic [HOUR_W-1:0]  cal_hour,
    input  logic [MIN_W-1:0]   cal_min,
    input  logic [SEC_W-1:0]   cal_sec,
    input  logic               wr_setup0,
    input  logic               wr_setup1,
    input  logic               wr_mask,
    input  logic               wr_force,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [WORD_W-1:0]  setup0_rd,
    output logic [WORD_W-1:0]  setup1_rd,
    output logic               irq_raw,
    output logic               irq_mask,
    output logic               irq_force,
    output logic               irq_out
);
    cal_t              live, alarm;
    logic [NFIELD-1:0] field_en;
    logic              arm, armed, match_now, match_event;

    always_comb begin
        live.year   = cal_year;
        live.month  = cal_month;
        live.day    = cal_day;
        live.wday   = cal_wday;
        live.hour   = cal_hour;
        live.minute = cal_min;
        live.second = cal_sec;
    end

    cal_alarm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_setup0 (wr_setup0),
        .wr_setup1 (wr_setup1),
        .wr_data   (wr_data),
        .alarm     (alarm),
        .field_en  (field_en),
        .arm       (arm),
        .armed     (armed),
        .setup0_rd (setup0_rd),
        .setup1_rd (setup1_rd)
    );

    cal_alarm_cmp u_cmp (
        .clk         (clk),
        .rst         (rst),
        .live        (live),
        .alarm       (alarm),
        .field_en    (field_en),
        .arm         (arm),
        .match_now   (match_now),
        .match_event (match_event)
    );

    cal_alarm_intc u_intc (
        .clk         (clk),
        .rst         (rst),
        .arm         (arm),
        .any_en      (|field_en),
        .match_now   (match_now),
        .match_event (match_event),
        .wr_mask     (wr_mask),
        .wr_force    (wr_force),
        .wr_bit      (wr_data[0]),
        .raw         (irq_raw),
        .mask        (irq_mask),
        .force_q     (irq_force),
        .line        (irq_out)
    );

    // R8: force alone drives the line high
    a_r8_force_wins: assert property (@(posedge clk) disable iff (rst)
        irq_force |-> irq_out);
    // R8: without force and mask the line stays low
    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (!irq_force && !irq_mask) |-> !irq_out);

endmodule

// File: tb/cal_alarm_irq_bench.sv
module cal_alarm_irq_bench;
    import cal_alarm_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [11:0] cal_year  = '0;
    logic [3:0]  cal_month = '0;
    logic [4:0]  cal_day   = '0;
    logic [2:0]  cal_wday  = '0;
    logic [4:0]  cal_hour  = '0;
    logic [5:0]  cal_min   = '0;
    logic [5:0]  cal_sec   = '0;
    logic wr_setup0 = 0, wr_setup1 = 0, wr_mask = 0, wr_force = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] setup0_rd, setup1_rd;
    logic irq_raw, irq_mask, irq_force, irq_out;

    cal_alarm_irq u_cal_alarm_irq (
        .clk(clk), .rst(rst),
        .cal_year(cal_year), .cal_month(cal_month), .cal_day(cal_day),
        .cal_wday(cal_wday), .cal_hour(cal_hour), .cal_min(cal_min),
        .cal_sec(cal_sec),
        .wr_setup0(wr_setup0), .wr_setup1(wr_setup1),
        .wr_mask(wr_mask), .wr_force(wr_force), .wr_data(wr_data),
        .setup0_rd(setup0_rd), .setup1_rd(setup1_rd),
        .irq_raw(irq_raw), .irq_mask(irq_mask), .irq_force(irq_force),
        .irq_out(irq_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk0(input int y, input int m, input int d,
                                        input bit ey, input bit em, input bit ed, input bit arm);
        logic [31:0] w = '0;
        w[23:12] = y[11:0]; w[11:8] = m[3:0]; w[4:0] = d[4:0];
        w[26] = ey; w[25] = em; w[24] = ed; w[28] = arm;
        return w;
    endfunction

    function automatic logic [31:0] mk1(input int wd, input int h, input int mi, input int s,
                                        input bit ew, input bit eh, input bit emi, input bit es);
        logic [31:0] w = '0;
        w[26:24] = wd[2:0]; w[20:16] = h[4:0]; w[13:8] = mi[5:0]; w[5:0] = s[5:0];
        w[31] = ew; w[30] = eh; w[29] = emi; w[28] = es;
        return w;
    endfunction

    typedef struct packed {
        logic [31:0] s0;
        logic [31:0] s1;
        logic        exp_raw;
    } vec_t;

    localparam int NV = 9;
    // live value for all vectors: 2024-02-29, weekday 4, 13:45:30
    localparam vec_t VECS [NV] = '{
        '{mk0(2024,2,29,1,0,0,1), mk1(0,0,0,0,0,0,0,0), 1'b1},   // R5 year only
        '{mk0(2024,2,29,1,1,1,1), mk1(4,13,45,30,1,1,1,1), 1'b1},// R5 all equal
        '{mk0(2024,2,29,1,1,1,1), mk1(4,13,45,31,1,1,1,1), 1'b0},// R9 second off
        '{mk0(0,0,0,0,0,0,1), mk1(0,0,0,31,0,0,0,1), 1'b0},     // R9 lone second off
        '{mk0(2024,7,1,1,0,0,1), mk1(0,9,0,0,0,0,0,0), 1'b1},    // R5 disabled differ
        '{mk0(2024,2,29,0,0,0,1), mk1(4,13,45,30,0,0,0,0), 1'b0},// R7 no enables
        '{mk0(2024,2,29,1,1,1,0), mk1(4,13,45,30,1,1,1,1), 1'b0},// R5 disarmed
        '{mk0(0,0,0,0,0,0,1), mk1(4,0,0,0,1,0,0,0), 1'b1},       // R5 weekday only
        '{mk0(2024,3,29,0,1,0,1), mk1(0,0,0,0,0,0,0,0), 1'b0}    // R9 month differs
    };

    task automatic wr(input int which, input logic [31:0] d);
        @(negedge clk);
        wr_data = d;
        case (which)
            0: wr_setup0 = 1;
            1: wr_setup1 = 1;
            2: wr_mask   = 1;
            default: wr_force = 1;
        endcase
        @(posedge clk);
        @(negedge clk);
        wr_setup0 = 0; wr_setup1 = 0; wr_mask = 0; wr_force = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_live();
        cal_year = 12'd2024; cal_month = 4'd2; cal_day = 5'd29;
        cal_wday = 3'd4; cal_hour = 5'd13; cal_min = 6'd45; cal_sec = 6'd30;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 setup0", setup0_rd, 32'h0);
        check("R1 setup1", setup1_rd, 32'h0);
        check("R1 raw", {31'b0, irq_raw}, 32'h0);
        check("R1 line", {29'b0, irq_mask, irq_force, irq_out}, 32'h0);

        // vector table
        set_live();
        for (int i = 0; i < NV; i++) begin
            wr(0, 32'h0);
            wr(1, VECS[i].s1);
            wr(0, VECS[i].s0);
            tick();
            check($sformatf("R5/R7/R9 vector %0d raw", i), {31'b0, irq_raw},
                  {31'b0, VECS[i].exp_raw});
        end

        // R2 / R4 setup word 0 layout and armed flag delay
        wr(0, 32'h0); tick();
        wr(0, 32'hffff_ffff);
        check("R2 setup0 mask, R4 armed not yet", setup0_rd, 32'h17ff_ff1f);
        tick();
        check("R4 armed flag set", setup0_rd, 32'h37ff_ff1f);
        wr(0, 32'h0);
        check("R4 armed still set one cycle", setup0_rd, 32'h2000_0000);
        tick();
        check("R4 armed flag clear", setup0_rd, 32'h0);
        // R3 setup word 1 layout
        wr(1, 32'hffff_ffff);
        check("R3 setup1 mask", setup1_rd, 32'hf71f_3f3f);

        // R5 edge timing: arm with seconds off, then move live second into match
        set_live();
        cal_sec = 6'd10;
        wr(1, mk1(0,0,0,12,0,0,0,1));
        wr(0, mk0(0,0,0,0,0,0,1));
        tick();
        check("R5 no match yet", {31'b0, irq_raw}, 32'h0);
        cal_sec = 6'd12;
        #1;
        check("R5 raw before edge", {31'b0, irq_raw}, 32'h0);
        tick();
        check("R5 raw after edge", {31'b0, irq_raw}, 32'h1);
        // R6 sticky after mismatch
        cal_sec = 6'd13;
        tick(); tick();
        check("R6 raw sticky", {31'b0, irq_raw}, 32'h1);

        // R8 mask/force combinations with raw=1
        check("R8 masked line", {31'b0, irq_out}, 32'h0);
        wr(2, 32'h1);
        check("R8 mask readback", {31'b0, irq_mask}, 32'h1);
        check("R8 raw&mask line", {31'b0, irq_out}, 32'h1);

        // R6 disarm clears raw on next edge
        wr(0, mk0(0,0,0,0,0,0,0));
        check("R6 raw before clear edge", {31'b0, irq_raw}, 32'h1);
        tick();
        check("R6 raw cleared", {31'b0, irq_raw}, 32'h0);
        check("R8 line low after clear", {31'b0, irq_out}, 32'h0);
        wr(3, 32'h1);
        check("R8 force readback", {31'b0, irq_force}, 32'h1);
        check("R8 force drives line", {31'b0, irq_out}, 32'h1);
        wr(3, 32'h0);
        wr(2, 32'h0);
        // R6 re-arm with live matching fires again
        cal_sec = 6'd12;
        wr(0, mk0(0,0,0,0,0,0,1));
        tick();
        check("R6 re-fire", {31'b0, irq_raw}, 32'h1);
        check("R8 mask off line", {31'b0, irq_out}, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule